// File: doc/BRIEF.md
# Dual-Compare Step Pulse Timer Channel

This block is one timer channel that produces step pulses for a motor driver on two output pins. A 16-bit up-counter runs freely from a prescaled copy of the system clock. Each pin has its own compare register. When the counter reaches that value, the pin is set, cleared or left alone, as its action field selects. Software schedules the next rising edge by adding the desired delay to the compare register. The edge therefore lands on an exact counter value, whatever the interrupt latency.

A third compare register, C, can force either pin low. Software loads it with the current count plus a short offset, which ends a pulse a fixed number of ticks after it began. Each compare on A or B raises a status flag. Reading the status word returns both flags and clears them. One level-sensitive interrupt line stays high while any enabled flag is set.

Software reaches the channel through a plain write and read strobe bus with a 4-bit word address. Reads are combinational: `rdata` is valid in the same cycle as `rdEn`, and side effects of the read take place at the following clock edge.

Top module: `pulse_timer_chan`

## Requirements
- R1: After reset the counter is 0 and stopped, both pins and `irq` are low, and the mode word, the enable mask and the status flags read as 0.
- R2: Mode word (address 1) bits [2:0] choose the tick rate: code 0 gives one count every 2 clocks, 1 every 8, 2 every 32, 3 every 128, and 4 to 7 every 1024. The count (address 5) does not change between ticks.
- R3: The counter only counts up, by one per tick. It wraps from 0xFFFF to 0, and no compare match ever reloads it.
- R4: A write to the control word (address 0) with bit 0 set starts counting, and with bit 1 set stops it. Bit 2 zeroes the counter and the prescaler. It does this whether or not the counter is running, and it does not start a stopped counter.
- R5: Mode bits [4:3] act on pin A when the count equals compare A (address 2) on a tick, and bits [6:5] act on pin B the same way for compare B (address 3). The codes are 01 set, 10 clear, 00 and 11 no effect. The pin changes on the clock edge of that tick and at no other edge.
- R6: When the count equals compare C (address 4) on a tick, mode bit 7 clears pin A and mode bit 8 clears pin B. When such a clear meets a set from compare A or B on the same tick, the pin ends low.
- R7: Reading address 6 returns bit 0 = compare A flag and bit 1 = compare B flag, and clears both. A match that happens on the clock edge ending such a read leaves its flag set.
- R8: Writing ones to address 8 sets enable bits, and writing ones to address 9 clears them. Address 10 reads the enable mask in bits [1:0]. Writing all ones to address 9 disables every source.
- R9: `irq` is high exactly while some flag is set whose enable bit is set. It falls after the status read that clears the flags.
- R10: The three compare registers read back the value last written, and writing them does not disturb the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; side effects at the next edge |
| addr | input | 4 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| outA | output | 1 | Step pulse pin A |
| outB | output | 1 | Step pulse pin B |
| irq | output | 1 | Level interrupt request |

## Verification
A prescaler that loses phase shows up as a wrong count the first time the count is read back. At the slow rates this can take up to a thousand cycles to appear, so the long-divisor cases are read at exact multiples of the divisor.

A compare or action fault appears at a pin on the single edge where the tick meets the match. The bench probes both sides of that edge, so a pin that moves one tick early or late is caught at once.

Faults in the flags and the mask show up on `irq` or on the next status read. The collision of a match with a status read is placed on one exact edge, because a flag lost there is only visible in the read that follows it.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE    = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPA    = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_CMPB    = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CMPC    = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_COUNT   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_STATUS  = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_IEN_SET = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_IEN_CLR = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_IEN_RD  = 4'd10;

  localparam int NUM_PINS = 2;
  localparam int MODE_W   = 9;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_RSVD = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic     cClrB;
    logic     cClrA;
    pin_act_e actB;
    pin_act_e actA;
    logic [2:0] divSel;
  } mode_t;

  typedef struct packed {
    logic                run;
    logic                restart;
    logic [NUM_PINS-1:0] ldCmp;
    logic                ldCmpC;
  } dp_ctl_t;

  function automatic int divShift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 3;
      3'd2:    return 5;
      3'd3:    return 7;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/ptc_datapath.sv
module ptc_datapath
  import ptc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dp_ctl_t                        ctl,
  input  mode_t                          mode,
  input  logic [CNT_W-1:0]               wdata,
  output logic [CNT_W-1:0]               count,
  output logic [NUM_PINS-1:0][CNT_W-1:0] cmpAB,
  output logic [CNT_W-1:0]               cmpC,
  output logic [NUM_PINS-1:0]            matchAB,
  output logic                           matchC,
  output logic                           tick,
  output logic [NUM_PINS-1:0]            pins
);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divM1;

  always_comb begin
    divM1 = PRE_W'((32'd1 << divShift(mode.divSel)) - 32'd1);
    tick  = ctl.run && !ctl.restart && (preCnt >= divM1);
  end

  // prescaler and counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
    end else if (ctl.restart) begin
      preCnt <= '0;
      count  <= '0;
    end else if (tick) begin
      preCnt <= '0;
      count  <= count + 1'b1;
    end else if (ctl.run) begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmpC <= '0;
    else if (ctl.ldCmpC) cmpC <= wdata;
  end

  assign matchC = tick && (count == cmpC);

  pin_act_e            pinAct [NUM_PINS];
  logic [NUM_PINS-1:0] pinClrC;

  always_comb begin
    pinAct[0]  = mode.actA;
    pinAct[1]  = mode.actB;
    pinClrC[0] = mode.cClrA;
    pinClrC[1] = mode.cClrB;
  end

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rstN) cmpAB[gi] <= '0;
      else if (ctl.ldCmp[gi]) cmpAB[gi] <= wdata;
    end

    assign matchAB[gi] = tick && (count == cmpAB[gi]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pins[gi] <= 1'b0;
      end else if (matchC && pinClrC[gi]) begin
        pins[gi] <= 1'b0;
      end else if (matchAB[gi]) begin
        case (pinAct[gi])
          ACT_SET: pins[gi] <= 1'b1;
          ACT_CLR: pins[gi] <= 1'b0;
          default: pins[gi] <= pins[gi];
        endcase
      end
    end
  end

endmodule

// File: rtl/ptc_control.sv
module ptc_control
  import ptc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [CNT_W-1:0]               wdata,
  input  logic [CNT_W-1:0]               count,
  input  logic [NUM_PINS-1:0][CNT_W-1:0] cmpAB,
  input  logic [CNT_W-1:0]               cmpC,
  input  logic [NUM_PINS-1:0]            matchAB,
  output dp_ctl_t                        ctl,
  output mode_t                          modeQ,
  output logic [CNT_W-1:0]               rdata,
  output logic                           irq
);

  logic                runQ;
  logic [NUM_PINS-1:0] maskQ;
  logic [NUM_PINS-1:0] flagQ;
  logic                wrCtrl;
  logic                rdStatus;

  assign wrCtrl   = wrEn && (addr == ADR_CTRL);
  assign rdStatus = rdEn && (addr == ADR_STATUS);

  always_comb begin
    ctl.run      = runQ;
    ctl.restart  = wrCtrl && wdata[2];
    ctl.ldCmp[0] = wrEn && (addr == ADR_CMPA);
    ctl.ldCmp[1] = wrEn && (addr == ADR_CMPB);
    ctl.ldCmpC   = wrEn && (addr == ADR_CMPC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
    end else if (wrCtrl) begin
      if (wdata[0]) runQ <= 1'b1;
      else if (wdata[1]) runQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= '0;
    else if (wrEn && (addr == ADR_MODE)) modeQ <= mode_t'(wdata[MODE_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (wrEn && (addr == ADR_IEN_SET)) begin
      maskQ <= maskQ | wdata[NUM_PINS-1:0];
    end else if (wrEn && (addr == ADR_IEN_CLR)) begin
      maskQ <= maskQ & ~wdata[NUM_PINS-1:0];
    end
  end

  // a match on the read edge survives the clear
  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else flagQ <= (flagQ & {NUM_PINS{!rdStatus}}) | matchAB;
  end

  assign irq = |(flagQ & maskQ);

  always_comb begin
    case (addr)
      ADR_MODE:   rdata = CNT_W'(modeQ);
      ADR_CMPA:   rdata = cmpAB[0];
      ADR_CMPB:   rdata = cmpAB[1];
      ADR_CMPC:   rdata = cmpC;
      ADR_COUNT:  rdata = count;
      ADR_STATUS: rdata = CNT_W'(flagQ);
      ADR_IEN_RD: rdata = CNT_W'(maskQ);
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/pulse_timer_chan.sv
module pulse_timer_chan
  import ptc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              outA,
  output logic              outB,
  output logic              irq
);

  dp_ctl_t                        ctl;
  mode_t                          modeQ;
  logic [CNT_W-1:0]               count;
  logic [NUM_PINS-1:0][CNT_W-1:0] cmpAB;
  logic [CNT_W-1:0]               cmpC;
  logic [NUM_PINS-1:0]            matchAB;
  logic                           matchC;
  logic                           tick;
  logic [NUM_PINS-1:0]            pins;

  ptc_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .count(count), .cmpAB(cmpAB), .cmpC(cmpC),
    .matchAB(matchAB), .ctl(ctl), .modeQ(modeQ), .rdata(rdata), .irq(irq)
  );

  ptc_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mode(modeQ), .wdata(wdata),
    .count(count), .cmpAB(cmpAB), .cmpC(cmpC), .matchAB(matchAB),
    .matchC(matchC), .tick(tick), .pins(pins)
  );

  assign outA = pins[0];
  assign outB = pins[1];

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
  import ptc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [CNT_W-1:0]    count,
  input logic                tick,
  input logic                restart,
  input logic [NUM_PINS-1:0] matchAB,
  input logic                matchC,
  input mode_t               modeQ,
  input logic                outA,
  input logic                outB,
  input logic                irq,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   addr
);

  logic rdStat;
  assign rdStat = rdEn && (addr == ADR_STATUS);

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !restart) |=> $stable(count)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (count == $past(count) + 1'b1)); // R3

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (count == '0)); // R4

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(outA) && $stable(outB))); // R5

  AST_SET_A: assert property (@(posedge clk) disable iff (!rstN)
    (matchAB[0] && modeQ.actA == ACT_SET && !(matchC && modeQ.cClrA)) |=> outA); // R5

  AST_C_WINS_A: assert property (@(posedge clk) disable iff (!rstN)
    (matchC && modeQ.cClrA) |=> !outA); // R6

  AST_C_WINS_B: assert property (@(posedge clk) disable iff (!rstN)
    (matchC && modeQ.cClrB) |=> !outB); // R6

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rdStat && matchAB == '0) |=> !irq); // R9

endmodule

bind pulse_timer_chan ptc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .count(count), .tick(tick), .restart(ctl.restart),
  .matchAB(matchAB), .matchC(matchC), .modeQ(modeQ), .outA(outA),
  .outB(outB), .irq(irq), .rdEn(rdEn), .addr(addr)
);

// File: tb/tb_pulse_timer_chan.sv
module tb_pulse_timer_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        outA, outB, irq;
  logic        probe = 1'b0;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pulse_timer_chan dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .outA(outA), .outB(outB), .irq(irq)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 pins {irq,B,A}, 2 discard
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];

  // monitor: pops one expectation per probed cycle
  always @(negedge clk) begin
    #1;
    if (probe && sbq.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = sbq.pop_front();
      got = (it.kind == 1) ? {13'd0, irq, outB, outA} : rdata;
      if (it.kind != 2) begin
        nChk++;
        if (got !== it.exp) begin
          nFail++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.kind = 0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    rdEn = 1'b1; addr = a; probe = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; probe = 1'b0;
  endtask

  task automatic rdAny(input logic [3:0] a);
    item_t it;
    it.kind = 2; it.exp = '0; it.tag = "none";
    sbq.push_back(it);
    rdEn = 1'b1; addr = a; probe = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; probe = 1'b0;
  endtask

  task automatic pinChk(input logic [2:0] e, input string tag);
    item_t it;
    it.kind = 1; it.exp = {13'd0, e}; it.tag = tag;
    sbq.push_back(it);
    probe = 1'b1;
    @(negedge clk);
    probe = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(4'd5, 16'h0000, "R1");
    rd(4'd10, 16'h0000, "R1");
    rd(4'd6, 16'h0000, "R1");
    rd(4'd1, 16'h0000, "R1");
    pinChk(3'b000, "R1");

    // R5 set actions on A and B, counter stopped while configuring
    wr(4'd1, 16'h0028);
    wr(4'd2, 16'd3);
    wr(4'd3, 16'd6);
    wr(4'd0, 16'h0005);
    idle(7);
    pinChk(3'b000, "R5");
    pinChk(3'b001, "R5");
    idle(4);
    pinChk(3'b001, "R5");
    pinChk(3'b011, "R5");

    // R6 compare C clears, wins a tie with compare B
    wr(4'd0, 16'h0002);
    wr(4'd1, 16'h01A8);
    rd(4'd1, 16'h01A8, "R6");
    wr(4'd2, 16'd2);
    wr(4'd3, 16'd1);
    wr(4'd4, 16'd1);
    wr(4'd0, 16'h0005);
    idle(3);
    pinChk(3'b011, "R6");
    pinChk(3'b000, "R6");
    idle(1);
    pinChk(3'b001, "R6");
    wr(4'd4, 16'd5);
    idle(3);
    pinChk(3'b001, "R6");
    pinChk(3'b000, "R6");

    // R8 mask set and clear
    wr(4'd0, 16'h0002);
    wr(4'd1, 16'h0000);
    rdAny(4'd6);
    rd(4'd6, 16'h0000, "R7");
    wr(4'd8, 16'h0003);
    rd(4'd10, 16'h0003, "R8");
    wr(4'd9, 16'h0001);
    rd(4'd10, 16'h0002, "R8");
    wr(4'd9, 16'hFFFF);
    rd(4'd10, 16'h0000, "R8");
    wr(4'd8, 16'h0002);

    // R9 and R7 flags, irq level, read collision
    wr(4'd2, 16'd3);
    wr(4'd3, 16'd3);
    wr(4'd0, 16'h0005);
    idle(7);
    pinChk(3'b000, "R9");
    pinChk(3'b100, "R9");
    rd(4'd6, 16'h0003, "R7");
    pinChk(3'b000, "R9");
    wr(4'd2, 16'd8);
    idle(5);
    rd(4'd6, 16'h0000, "R7");
    rd(4'd6, 16'h0001, "R7");
    rd(4'd6, 16'h0000, "R7");
    pinChk(3'b000, "R9");

    // R10 compare readback
    wr(4'd4, 16'hBEEF);
    rd(4'd4, 16'hBEEF, "R10");
    rd(4'd2, 16'd8, "R10");
    rd(4'd3, 16'd3, "R10");

    // R4 stop and restart while stopped
    wr(4'd0, 16'h0005);
    idle(8);
    wr(4'd0, 16'h0002);
    rd(4'd5, 16'd4, "R4");
    idle(10);
    rd(4'd5, 16'd4, "R4");
    wr(4'd0, 16'h0004);
    rd(4'd5, 16'd0, "R4");
    idle(4);
    rd(4'd5, 16'd0, "R4");

    // R2 prescaler rates
    wr(4'd1, 16'h0000);
    wr(4'd0, 16'h0005);
    idle(20);
    rd(4'd5, 16'd10, "R2");
    wr(4'd1, 16'h0002);
    wr(4'd0, 16'h0005);
    idle(64);
    rd(4'd5, 16'd2, "R2");
    wr(4'd1, 16'h0004);
    wr(4'd0, 16'h0005);
    idle(2048);
    rd(4'd5, 16'd2, "R2");
    wr(4'd1, 16'h0007);
    wr(4'd0, 16'h0005);
    idle(1024);
    rd(4'd5, 16'd1, "R2");

    // R3 wrap of the free-running counter
    wr(4'd1, 16'h0000);
    wr(4'd0, 16'h0005);
    idle(131072);
    rd(4'd5, 16'd0, "R3");
    idle(1);
    rd(4'd5, 16'd1, "R3");

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule